// File: doc/BRIEF.md
# Retention Failure Bit Recovery

This block is used after the error-correcting decoder gives up on a page. It repairs bits in that page that charge leakage has moved across a read boundary. The caller senses every cell of the page three times. The first read is at the optimum read reference, the second is a fixed margin below it and the third is the same margin above it. The caller then waits for more retention time and senses the page once more at the lower reference. The four results for each cell are streamed into the block one cell per cycle.

Each cell is classified from its three-read pattern. A cell that sits firmly in one state keeps its optimum-reference value. A cell near the boundary is classed as risky. A risky cell whose late read shows that its threshold kept falling is taken to be a fast leaker, which means it was originally in the higher state, so its output bit is forced to the higher-state value. A risky slow leaker keeps its optimum-reference value. Patterns that cannot come from a real cell pass through unchanged and are counted. The corrected stream goes back to the decoder for another attempt. The block reports a done pulse, the number of bits it flipped and the saturating count of impossible patterns.

Top module: `retention_recover`

## Requirements
- R1: A page begins only on a `fail_start` pulse while the block is idle. Cell data offered while idle produces no `out_valid` and leaves both counts unchanged.
- R2: A sensed bit is 1 when the threshold is above that reference and 0 when it is below. The pattern is read as (`rd_low`, `rd_mid`, `rd_high`). Only 000, 100, 110 and 111 are legal.
- R3: A cell with pattern 000 or 111 outputs its `rd_mid` value, whatever `rd_late` is.
- R4: A risky cell (pattern 100 or 110) with `rd_late` = 1 is a slow leaker and outputs its `rd_mid` value.
- R5: A risky cell with `rd_late` = 0 is a fast leaker and outputs 1, the higher-state value. `flip_count` increments exactly when this changes the bit, that is, when `rd_mid` was 0.
- R6: An illegal pattern (010, 001, 011, 101) outputs `rd_mid` and is never flipped. `illegal_count` increments for it and saturates at 2^ERR_W-1.
- R7: Each accepted cell produces exactly one `out_valid` cycle. It appears on the cycle after the cell is accepted, and cells come out in input order.
- R8: `page_done` pulses for one cycle together with the output of cell PAGE_BITS-1. At that cycle both counts hold the page's final totals. Both counts read 0 on the cycle after the next accepted `fail_start`.
- R9: A `fail_start` pulse while a page is in progress is ignored.
- R10: Cycles with `in_valid` low inside a page are skipped. They do not advance the cell position and they produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fail_start | input | 1 | Decoder reports uncorrectable page; starts recovery |
| in_valid | input | 1 | The four read bits of the current cell are valid |
| rd_low | input | 1 | Read at optimum reference minus margin |
| rd_mid | input | 1 | Read at optimum reference |
| rd_high | input | 1 | Read at optimum reference plus margin |
| rd_late | input | 1 | Read at lower reference after extra retention time |
| out_valid | output | 1 | Corrected bit is valid |
| out_bit | output | 1 | Corrected cell bit |
| page_done | output | 1 | One-cycle pulse with the last corrected bit |
| flip_count | output | $clog2(PAGE_BITS+1) | Bits flipped in the current page |
| illegal_count | output | ERR_W | Saturating count of impossible patterns |

## Verification
The bench builds the block with PAGE_BITS = 16 and ERR_W = 2. A 16-cell page is then exactly the 16 combinations of the four read bits, so one page covers every classification. A 2-bit error counter saturates inside a single page, because eight illegal combinations exceed its limit of 3. A second page uses a different pattern list with idle gaps, a stray start pulse and more fast leakers. This exercises page restart, count clearing and ignored stimulus at a size where every cell is checked.

// File: rtl/rfr_pkg.sv
package rfr_pkg;

    typedef enum logic [1:0] {
        CELL_LOW   = 2'd0,
        CELL_HIGH  = 2'd1,
        CELL_RISKY = 2'd2,
        CELL_BAD   = 2'd3
    } cell_kind_e;

    typedef struct packed {
        logic lo;
        logic mid;
        logic hi;
        logic late;
    } sense_t;

    typedef struct packed {
        logic bit_out;
        logic flipped;
        logic illegal;
    } verdict_t;

    function automatic cell_kind_e classify(input sense_t s);
        unique case ({s.lo, s.mid, s.hi})
            3'b000:  return CELL_LOW;
            3'b111:  return CELL_HIGH;
            3'b100,
            3'b110:  return CELL_RISKY;
            default: return CELL_BAD;
        endcase
    endfunction

    function automatic verdict_t decide(input sense_t s);
        verdict_t v;
        v.bit_out = s.mid;
        v.flipped = 1'b0;
        v.illegal = 1'b0;
        unique case (classify(s))
            CELL_RISKY: begin
                if (!s.late) begin
                    v.bit_out = 1'b1;
                    v.flipped = ~s.mid;
                end
            end
            CELL_BAD: v.illegal = 1'b1;
            default: ;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/rfr_seq.sv
module rfr_seq #(
    parameter int PAGE_BITS = 16384
) (
    input  logic clk,
    input  logic rst,
    input  logic fail_start,
    input  logic in_valid,
    output logic accept,
    output logic clear,
    output logic last
);
    localparam int IW = (PAGE_BITS > 1) ? $clog2(PAGE_BITS) : 1;
    localparam logic [IW-1:0] LAST_IDX = IW'(PAGE_BITS - 1);

    typedef enum logic {ST_IDLE, ST_RUN} seq_state_e;

    seq_state_e    state;
    logic [IW-1:0] idx;

    assign accept = (state == ST_RUN) && in_valid;
    assign clear  = (state == ST_IDLE) && fail_start;
    assign last   = accept && (idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            idx   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (fail_start) begin
                        state <= ST_RUN;
                        idx   <= '0;
                    end
                end
                ST_RUN: begin
                    if (accept) begin
                        if (last) begin
                            state <= ST_IDLE;
                            idx   <= '0;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_page_ends_R8: assert property (@(posedge clk) disable iff (rst)
        last |=> (state == ST_IDLE));

    assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RUN && fail_start && !last) |=> (state == ST_RUN));

endmodule

// File: rtl/rfr_cellpath.sv
module rfr_cellpath
    import rfr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     accept,
    input  logic     last,
    input  sense_t   sense,
    output logic     flip_evt,
    output logic     bad_evt,
    output logic     out_valid,
    output logic     out_bit,
    output logic     page_done
);
    verdict_t verdict;

    always_comb begin
        verdict  = decide(sense);
        flip_evt = accept && verdict.flipped;
        bad_evt  = accept && verdict.illegal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_bit   <= 1'b0;
            page_done <= 1'b0;
        end else begin
            out_valid <= accept;
            page_done <= last;
            if (accept) out_bit <= verdict.bit_out;
        end
    end

    assert_out_follows_R7: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(accept));

    assert_done_with_bit_R8: assert property (@(posedge clk) disable iff (rst)
        page_done |-> out_valid);

    assert_flip_upward_R5: assert property (@(posedge clk) disable iff (rst)
        flip_evt |=> (out_valid && out_bit));

    assert_bad_passthru_R6: assert property (@(posedge clk) disable iff (rst)
        bad_evt |=> (out_bit == $past(sense.mid)));

endmodule

// File: rtl/rfr_tally.sv
module rfr_tally #(
    parameter int CW    = 15,
    parameter int ERR_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             flip_evt,
    input  logic             bad_evt,
    output logic [CW-1:0]    flip_count,
    output logic [ERR_W-1:0] illegal_count
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            flip_count    <= '0;
            illegal_count <= '0;
        end else begin
            if (flip_evt) flip_count <= flip_count + 1'b1;
            if (bad_evt && illegal_count != ERR_MAX)
                illegal_count <= illegal_count + 1'b1;
        end
    end

    assert_err_saturates_R6: assert property (@(posedge clk) disable iff (rst)
        (illegal_count == ERR_MAX && !clear) |=> (illegal_count == ERR_MAX));

    assert_flip_monotonic_R5: assert property (@(posedge clk) disable iff (rst)
        (!clear && !flip_evt) |=> $stable(flip_count));

endmodule

// File: rtl/retention_recover.sv
module retention_recover
    import rfr_pkg::*;
#(
    parameter int PAGE_BITS = 16384,
    parameter int ERR_W     = 8,
    localparam int CW       = $clog2(PAGE_BITS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fail_start,
    input  logic             in_valid,
    input  logic             rd_low,
    input  logic             rd_mid,
    input  logic             rd_high,
    input  logic             rd_late,
    output logic             out_valid,
    output logic             out_bit,
    output logic             page_done,
    output logic [CW-1:0]    flip_count,
    output logic [ERR_W-1:0] illegal_count
);
    logic   accept, clear, last;
    logic   flip_evt, bad_evt;
    sense_t sense;

    assign sense = '{lo: rd_low, mid: rd_mid, hi: rd_high, late: rd_late};

    rfr_seq #(.PAGE_BITS(PAGE_BITS)) u_seq (
        .clk(clk), .rst(rst), .fail_start(fail_start), .in_valid(in_valid),
        .accept(accept), .clear(clear), .last(last)
    );

    rfr_cellpath u_path (
        .clk(clk), .rst(rst), .accept(accept), .last(last), .sense(sense),
        .flip_evt(flip_evt), .bad_evt(bad_evt),
        .out_valid(out_valid), .out_bit(out_bit), .page_done(page_done)
    );

    rfr_tally #(.CW(CW), .ERR_W(ERR_W)) u_tally (
        .clk(clk), .rst(rst), .clear(clear),
        .flip_evt(flip_evt), .bad_evt(bad_evt),
        .flip_count(flip_count), .illegal_count(illegal_count)
    );

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (!accept && !clear) |=> (!out_valid && $stable(flip_count) && $stable(illegal_count)));

endmodule

// File: tb/sim_retention_recover.sv
module sim_retention_recover;
    localparam int PB = 16;
    localparam int EW = 2;
    localparam int CW = $clog2(PB + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fail_start = 1'b0, in_valid = 1'b0;
    logic rd_low = 1'b0, rd_mid = 1'b0, rd_high = 1'b0, rd_late = 1'b0;
    logic out_valid, out_bit, page_done;
    logic [CW-1:0] flip_count;
    logic [EW-1:0] illegal_count;

    int checks = 0, errors = 0;
    bit running = 0;
    int pos = 0, exp_flips = 0, exp_bad = 0;
    bit pend_v = 0, pend_b = 0, pend_d = 0;

    always #2 clk = ~clk;

    retention_recover #(.PAGE_BITS(PB), .ERR_W(EW)) u0 (
        .clk(clk), .rst(rst), .fail_start(fail_start), .in_valid(in_valid),
        .rd_low(rd_low), .rd_mid(rd_mid), .rd_high(rd_high), .rd_late(rd_late),
        .out_valid(out_valid), .out_bit(out_bit), .page_done(page_done),
        .flip_count(flip_count), .illegal_count(illegal_count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // returns {bit, flipped, illegal} from R2..R6
    function automatic logic [2:0] model(input logic [3:0] p);
        logic lo, mi, hi, lt;
        {lo, mi, hi, lt} = p;
        if ({lo, mi, hi} == 3'b100 || {lo, mi, hi} == 3'b110) begin
            if (!lt) return {1'b1, ~mi, 1'b0};
            return {mi, 1'b0, 1'b0};
        end
        if ({lo, mi, hi} == 3'b000 || {lo, mi, hi} == 3'b111)
            return {mi, 1'b0, 1'b0};
        return {mi, 1'b0, 1'b1};
    endfunction

    task automatic cyc(input bit st, input bit v, input logic [3:0] p);
        logic [2:0] m;
        bit acc;
        @(negedge clk);
        check(out_valid == pend_v, "R7/R1/R10 out_valid", out_valid, pend_v);
        if (pend_v) check(out_bit == pend_b, "R3/R4/R5/R6 out_bit", out_bit, pend_b);
        check(page_done == pend_d, "R8 page_done", page_done, pend_d);
        if (pend_d) begin
            check(flip_count == exp_flips, "R5 flip_count", flip_count, exp_flips);
            check(illegal_count == (exp_bad > 3 ? 3 : exp_bad), "R6 illegal_count",
                  illegal_count, exp_bad > 3 ? 3 : exp_bad);
        end
        fail_start = st;
        in_valid   = v;
        {rd_low, rd_mid, rd_high, rd_late} = p;
        m = model(p);
        acc = running && v;
        pend_v = acc;
        pend_b = m[2];
        pend_d = 1'b0;
        if (acc) begin
            exp_flips += m[1];
            exp_bad   += m[0];
            pos++;
            if (pos == PB) begin
                running = 0;
                pend_d = 1'b1;
            end
        end else if (!running && st) begin
            running = 1;
            pos = 0;
            exp_flips = 0;
            exp_bad = 0;
        end
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 0, "reset out_valid", out_valid, 0);
        check(page_done == 0, "reset page_done", page_done, 0);
        check(flip_count == 0, "reset flip_count", flip_count, 0);
        check(illegal_count == 0, "reset illegal_count", illegal_count, 0);

        // R1: data offered while idle is ignored
        for (int i = 0; i < 6; i++) cyc(0, 1, 4'b1000);
        check(flip_count == 0, "R1 idle flips", flip_count, 0);

        // page 1: every combination of the four reads (R2..R6)
        cyc(1, 0, 4'b0000);
        for (int i = 0; i < PB; i++) cyc(0, 1, 4'(i));
        cyc(0, 0, 4'b0000);
        cyc(0, 0, 4'b0000);

        // R8: counts clear after next start
        cyc(1, 0, 4'b0000);
        cyc(0, 0, 4'b0000);
        check(flip_count == 0, "R8 flip_count cleared", flip_count, 0);
        check(illegal_count == 0, "R8 illegal_count cleared", illegal_count, 0);

        // page 2: gaps (R10), stray start (R9), many fast leakers
        for (int i = 0; i < PB; i++) begin
            logic [3:0] p;
            case (i % 4)
                0: p = 4'b1000;
                1: p = 4'b1100;
                2: p = 4'b1001;
                default: p = 4'b0101;
            endcase
            cyc(i == 5, 1, p);
            if (i % 3 == 0) cyc(0, 0, 4'b1000);
        end
        cyc(0, 0, 4'b0000);
        cyc(0, 1, 4'b1000);
        cyc(0, 0, 4'b0000);
        check(flip_count == PB / 4, "R5 page2 flips held", flip_count, PB / 4);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule